// File: doc/BRIEF.md
# Conditional Jump Fetch Sequencer

This block sequences instruction fetch for a small processor whose program memory is eight bits wide and whose program counter is 24 bits wide. Each instruction starts with a single opcode byte. Almost every opcode is treated as a one-byte no-op. The only opcodes the block acts on are conditional absolute jumps. For one of those, the sequencer reads the three address bytes that follow the opcode. It then tests the selected condition against the zero and carry flags. If the condition holds, it loads the assembled target into the program counter. If not, execution continues with the next byte in memory.

Memory is reached through a plain request/ready port. The sequencer raises a request for one cycle with the address set to the current program counter. It then waits, for as many cycles as needed, until the memory answers with ready and a data byte. Decode and the condition test each occupy a parameterised number of cycles. This lets a fast clock be kept even when those steps would not fit in one period. The program counter, the latched opcode and a two-bit state code are brought out for the rest of the core.

Top module: `jump_fetch_seq`

## Requirements
- R1: While reset is low and right after it is released, the PC is 0x000000, the opcode output is 0x00 and the state code is 0 (request).
- R2: Every byte read is one request cycle with `mem_req` high and `mem_addr` equal to the PC. It is followed by a wait state that lasts until `mem_ready` is high. `mem_ready` has no effect in any state other than wait.
- R3: The PC increases by one, modulo 2^24, in exactly the cycle a byte is accepted in the wait state. It holds its value in every other cycle unless a jump is taken.
- R4: An opcode is a jump when bits 7:3 equal 11000. Any other opcode is a one-byte no-op that leads straight back to the opcode request.
- R5: The condition code is opcode bits 2:0. The codes are: 0 always, 1 zero flag set, 2 zero flag clear, 3 carry set, 4 carry clear. Codes 5, 6 and 7 are never taken. Flags are sampled in the last condition cycle.
- R6: For a jump, the three bytes after the opcode form the target with the least significant byte first. A taken jump loads the target into the PC at the end of the condition stage. A jump that is not taken leaves the PC at the opcode address plus four.
- R7: Decode lasts DEC_CYC cycles. The condition stage lasts COND_CYC cycles. Neither stage changes the PC, except for the load at the end of the condition stage.
- R8: The state code reads 0 for request, 1 for wait, 2 for decode and 3 for condition test.
- R9: The PC wraps from 0xFFFFFF to 0x000000 when a byte is accepted at the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | ADDR_W | Read address (the PC) |
| mem_ready | input | 1 | Memory has placed the byte on mem_rdata |
| mem_rdata | input | 8 | Byte returned by memory |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc | output | ADDR_W | Program counter |
| opcode | output | 8 | Last opcode fetched |
| state | output | 2 | Sequencer state code |

## Verification
The bench drives memory latency from zero to three cycles. It also toggles `mem_ready` when no read is pending, so a design that accepts a byte outside the wait state would step the PC early and fall out of step with the model. The program runs through every condition code, including 5 and 7, with the flags changing on their own. A design that decodes the codes wrongly or samples the flags at the wrong time would jump, or fail to jump, and show a different PC. One jump targets 0xFFFFFE, so the fall-through walks over the top of the address space. A counter that does not wrap, or that gathers the address bytes in the wrong order, would end up at a wrong address and read different bytes.

// File: rtl/jfs_pkg.sv
package jfs_pkg;

  typedef enum logic [1:0] {
    ST_REQ  = 2'd0,
    ST_WAIT = 2'd1,
    ST_DEC  = 2'd2,
    ST_COND = 2'd3
  } seq_state_e;

  localparam logic [4:0] JUMP_PREFIX = 5'b11000;

  // opcode class test
  function automatic logic is_jump(input logic [7:0] op);
    return op[7:3] == JUMP_PREFIX;
  endfunction

  // condition evaluation against the flags
  function automatic logic cond_met(input logic [2:0] cc, input logic z, input logic c);
    logic hit;
    case (cc)
      3'd0:    hit = 1'b1;
      3'd1:    hit = z;
      3'd2:    hit = !z;
      3'd3:    hit = c;
      3'd4:    hit = !c;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/jfs_tstate_timer.sv
module jfs_tstate_timer #(
  parameter int unsigned CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic last
);

  generate
    if (CYC <= 1) begin : g_single
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign last = active;
    end else begin : g_count
      localparam int unsigned CW = $clog2(CYC);
      logic [CW-1:0] cnt;

      assign last = active && (cnt == CW'(CYC - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!active) cnt <= '0;
        else if (last)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/jfs_pc.sv
module jfs_pc #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] pc
);

  function automatic logic [ADDR_W-1:0] next_pc(
    input logic [ADDR_W-1:0] cur,
    input logic              do_inc,
    input logic              do_load,
    input logic [ADDR_W-1:0] tgt
  );
    if (do_load)     return tgt;
    else if (do_inc) return cur + ADDR_W'(1);
    else             return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= next_pc(pc, inc, load, load_val);
  end

endmodule

// File: rtl/jfs_ctrl.sv
module jfs_ctrl
  import jfs_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ready,
  input  logic [7:0]        mem_rdata,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              dec_last,
  input  logic              cond_last,
  output seq_state_e        state_q,
  output logic [7:0]        opcode_q,
  output logic [ADDR_W-1:0] target_q,
  output logic              byte_take,
  output logic              pc_load,
  output logic              dec_active,
  output logic              cond_active,
  output logic              mem_req
);

  localparam int unsigned ADDR_BYTES = ADDR_W / 8;
  localparam int unsigned IDX_W      = $clog2(ADDR_BYTES + 1);

  logic [IDX_W-1:0] idx_q;   // 0 = opcode byte, k = address byte k

  assign mem_req     = (state_q == ST_REQ);
  assign byte_take   = (state_q == ST_WAIT) && mem_ready;
  assign dec_active  = (state_q == ST_DEC);
  assign cond_active = (state_q == ST_COND);
  assign pc_load     = cond_last && cond_met(opcode_q[2:0], flag_z, flag_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_REQ;
      idx_q    <= '0;
      opcode_q <= '0;
      target_q <= '0;
    end else begin
      case (state_q)
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_ready) begin
            if (idx_q == '0) begin
              opcode_q <= mem_rdata;
              state_q  <= ST_DEC;
            end else begin
              for (int k = 0; k < int'(ADDR_BYTES); k++) begin
                if (idx_q == IDX_W'(k + 1)) target_q[8*k +: 8] <= mem_rdata;
              end
              if (idx_q == IDX_W'(ADDR_BYTES)) begin
                state_q <= ST_COND;
              end else begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_REQ;
              end
            end
          end
        end
        ST_DEC: begin
          if (dec_last) begin
            idx_q   <= is_jump(opcode_q) ? IDX_W'(1) : '0;
            state_q <= ST_REQ;
          end
        end
        default: begin
          if (cond_last) begin
            idx_q   <= '0;
            state_q <= ST_REQ;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/jump_fetch_seq.sv
module jump_fetch_seq
  import jfs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DEC_CYC  = 2,
  parameter int unsigned COND_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [7:0]        mem_rdata,
  input  logic              flag_z,
  input  logic              flag_c,
  output logic [ADDR_W-1:0] pc,
  output logic [7:0]        opcode,
  output logic [1:0]        state
);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] target_q;
  logic              byte_take;
  logic              pc_load;
  logic              dec_active, cond_active;
  logic              dec_last, cond_last;

  jfs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .dec_last   (dec_last),
    .cond_last  (cond_last),
    .state_q    (state_q),
    .opcode_q   (opcode),
    .target_q   (target_q),
    .byte_take  (byte_take),
    .pc_load    (pc_load),
    .dec_active (dec_active),
    .cond_active(cond_active),
    .mem_req    (mem_req)
  );

  jfs_tstate_timer #(.CYC(DEC_CYC)) u_dec_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .active(dec_active),
    .last  (dec_last)
  );

  jfs_tstate_timer #(.CYC(COND_CYC)) u_cond_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .active(cond_active),
    .last  (cond_last)
  );

  jfs_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (byte_take),
    .load    (pc_load),
    .load_val(target_q),
    .pc      (pc)
  );

  assign mem_addr = pc;
  assign state    = state_q;

endmodule

// File: rtl/jfs_checker.sv
module jfs_checker #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              byte_take,
  input logic [ADDR_W-1:0] pc,
  input logic [1:0]        state
);

  // R2: a request lasts exactly one cycle
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R2: request always moves into the wait state
  a_r2_req_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> state == 2'd1);

  // R3: without ready the sequencer holds in wait with a steady PC
  a_r3_hold_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && !mem_ready) |=> (state == 2'd1 && $stable(pc)));

  // R3, R9: accepted byte steps the PC by one, wrapping at the top
  a_r3_step_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |=> pc == $past(pc) + ADDR_W'(1));

  // R7: decode never moves the PC
  a_r7_dec_no_pc_move: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd2 |=> $stable(pc));

  // R2: the request state never moves the PC
  a_r2_req_no_pc_move: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd0 |=> $stable(pc));

endmodule

bind jump_fetch_seq jfs_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_jump_fetch_seq.sv
`timescale 1ns/1ps
module sim_jump_fetch_seq;
  localparam int AW  = 24;
  localparam int DEC = 2;
  localparam int CND = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst_n = 1'b0;
  logic          ready = 1'b0;
  logic [7:0]    rdata = 8'h00;
  logic          fz = 1'b0, fc = 1'b0;
  logic          req;
  logic [AW-1:0] maddr, pc;
  logic [7:0]    op;
  logic [1:0]    st;

  jump_fetch_seq #(.ADDR_W(AW), .DEC_CYC(DEC), .COND_CYC(CND)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(req), .mem_addr(maddr),
    .mem_ready(ready), .mem_rdata(rdata), .flag_z(fz), .flag_c(fc),
    .pc(pc), .opcode(op), .state(st)
  );

  int checks = 0, fails = 0;
  bit running = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // program memory
  logic [7:0] mem [int];
  function automatic logic [7:0] rd(input logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction
  task automatic put4(input int a, input logic [7:0] o, input logic [23:0] t);
    mem[a] = o; mem[a+1] = t[7:0]; mem[a+2] = t[15:8]; mem[a+3] = t[23:16];
  endtask

  // behavioural reference model
  int            m_st, m_idx, m_cnt, m_prev;
  logic [AW-1:0] m_pc, m_tgt;
  logic [7:0]    m_op;
  int            wraps = 0;
  int            taken_cc [8];
  int            miss_cc  [8];

  function automatic bit take_it(input logic [2:0] cc, input logic z, input logic c);
    if (cc == 0) return 1;
    if (cc == 1) return z;
    if (cc == 2) return !z;
    if (cc == 3) return c;
    if (cc == 4) return !c;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_cnt = 0; m_pc = '0; m_tgt = '0; m_op = 8'h00; m_prev = 0;
    end else begin
      m_prev = m_st;
      case (m_st)
        0: m_st = 1;
        1: if (ready) begin
             if (m_pc == {AW{1'b1}}) wraps++;
             m_pc = m_pc + 1;
             if (m_idx == 0) begin m_op = rdata; m_st = 2; m_cnt = 0; end
             else begin
               m_tgt = {rdata, m_tgt[AW-1:8]};
               if (m_idx == 3) begin m_st = 3; m_cnt = 0; end
               else begin m_idx++; m_st = 0; end
             end
           end
        2: if (m_cnt == DEC - 1) begin
             m_idx = (m_op[7:3] == 5'b11000) ? 1 : 0; m_st = 0;
           end else m_cnt++;
        default: if (m_cnt == CND - 1) begin
             if (take_it(m_op[2:0], fz, fc)) begin m_pc = m_tgt; taken_cc[m_op[2:0]]++; end
             else miss_cc[m_op[2:0]]++;
             m_idx = 0; m_st = 0;
           end else m_cnt++;
      endcase
    end
  end

  // comparison, memory responder and stimulus on the falling edge
  logic [15:0]   lfsr = 16'hACE1;
  bit            pend = 0;
  int            lat = 0;
  logic [AW-1:0] paddr = '0;
  int            idle = 0;

  always @(negedge clk) begin
    if (running) begin
      chk(req == (m_st == 0), "R2 mem_req", req, m_st == 0);
      chk(maddr == m_pc, "R2 mem_addr", maddr, m_pc);
      if (m_prev == 3) chk(pc == m_pc, "R5 R6 pc after condition", pc, m_pc);
      else             chk(pc == m_pc, "R3 R9 pc", pc, m_pc);
      chk(op == m_op, "R4 opcode", op, m_op);
      chk(st == 2'(m_st), "R7 R8 state", st, m_st);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready = 1'b0;
    if (rst_n && running) begin
      if (pend) begin
        if (lat == 0) begin ready = 1'b1; rdata = rd(paddr); pend = 0; end
        else lat--;
      end else begin
        // stray ready outside the wait state must be ignored (R2)
        ready = lfsr[12] & lfsr[3];
        rdata = lfsr[11:4];
      end
      if (req) begin pend = 1; lat = int'(lfsr[1:0]); paddr = maddr; idle = 0; end
      else idle++;
      if (idle > 100) begin
        fails++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", idle, 100);
        finish_run();
      end
    end
    fz = lfsr[5];
    fc = lfsr[9];
  end

  initial begin
    put4(32'h00, 8'hC0, 24'h000010);
    put4(32'h10, 8'hC1, 24'h000030);
    put4(32'h14, 8'hC2, 24'h000034);
    put4(32'h18, 8'hC3, 24'h000038);
    put4(32'h1C, 8'hC4, 24'h00003C);
    put4(32'h20, 8'hC5, 24'h000000);
    put4(32'h24, 8'hC7, 24'h000000);
    mem[32'h28] = 8'hC8;                   // not a jump: one-byte no-op
    put4(32'h29, 8'hC0, 24'hFFFFFE);
    put4(32'h30, 8'hC0, 24'h000014);
    put4(32'h34, 8'hC0, 24'h000018);
    put4(32'h38, 8'hC0, 24'h00001C);
    put4(32'h3C, 8'hC0, 24'h000020);

    repeat (3) @(negedge clk);
    chk(pc == '0, "R1 reset pc", pc, 0);
    chk(op == 8'h00, "R1 reset opcode", op, 0);
    chk(st == 2'd0, "R1 reset state", st, 0);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    chk(st == 2'd1 && pc == '0, "R1 first request from address zero", {st, pc}, {2'd1, 24'h0});
    repeat (6000) @(negedge clk);

    chk(wraps > 0, "R9 wrap at top address", wraps, 1);
    for (int c = 0; c < 5; c++) chk(taken_cc[c] > 0, "R5 code taken seen", c, taken_cc[c]);
    for (int c = 1; c < 5; c++) chk(miss_cc[c] > 0, "R5 code not taken seen", c, miss_cc[c]);
    chk(miss_cc[5] > 0 && miss_cc[7] > 0, "R5 codes 5 and 7 never taken", miss_cc[5], miss_cc[7]);
    finish_run();
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog timeout R2 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule